// File: doc/BRIEF.md
# Paired Event Counter Compare Unit

This block holds two performance counters that operate as a cross-coupled pair. Each counter takes a per-bus match strobe, picks either the request-side or the response-side strobe, and counts qualified events into a 32-bit register whose top bit acts as an overflow flag. A per-counter compare register is used in one of four ways, chosen by that counter's compare mode: it is ignored, it is a threshold that raises a compare status, it is a high-water mark refreshed at each sample boundary, or it forms one edge of an address window.

In window mode the 32-bit address field (transaction address bits 38 down to 7) must lie above counter 0's compare value and at or below counter 1's compare value. The resulting range hit gates the event strobe of every counter in window mode. Each counter can also be cleared by a reset event, and then keeps counting. The reset event can come from the partner's status becoming active, from the partner's qualified event, or from one of four external event pins.

Software reaches the block through a simple write port and a read port that returns its data one cycle later.

Top module: `evpair_monitor`

## Requirements
- R1: After a synchronous reset all counts, compare values, control fields, status bits, range_hit and rd_data are zero.
- R2: Control bit 0 selects the event source: 0 takes req_match[i], 1 takes rsp_match[i]. Each qualified event adds one to the count in the following cycle.
- R3: With compare mode 00 the compare register does not affect cmp_status, which stays clear.
- R4: With compare mode 01, cmp_status[i] is set one cycle after the cycle in which the 32-bit unsigned count, overflow bit included, is strictly greater than the compare register. The bit then stays set.
- R5: An increment that takes count bit 31 from 0 to 1 sets ovf_status[i]. The bit is sticky until a control write or a reset event clears it.
- R6: With compare mode 10, a sample_end pulse while the count exceeds the compare register loads the count into the compare register. The compare does not set status in this mode.
- R7: range_hit is asserted one cycle after txn_addr[38:7] is greater than counter 0's compare value and at most counter 1's compare value. A counter in compare mode 11 counts only when its strobe and the range hit coincide.
- R8: Reset select 001 clears a counter in the cycle after its partner's status goes from no bit set to some bit set.
- R9: Reset select 010 clears a counter in the cycle after its partner counted a qualified event.
- R10: Reset selects 100 to 111 clear the counter in the cycle that ext_evt[0] to ext_evt[3] is high. Selects 000 and 011 never clear it.
- R11: A reset event clears the count and both status bits. It wins over an increment in the same cycle, and counting resumes in the next cycle.
- R12: A write with wr_reg 0 loads control bits {reset select [5:3], compare mode [2:1], bus select [0]} and clears the status bits. wr_reg 1 loads the compare register and wr_reg 2 loads the count. A write to the count wins over a reset event or an increment in the same cycle. rd_data returns the selected register one cycle later, and a control read shows ovf_status in bit 8 and cmp_status in bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 1 | Counter addressed by the write |
| wr_reg | input | 2 | 0 control, 1 compare, 2 count |
| wr_data | input | 32 | Write data |
| rd_idx | input | 1 | Counter addressed by the read |
| rd_reg | input | 2 | 0 control and status, 1 compare, 2 count, 3 zero |
| rd_data | output | 32 | Read data, one cycle after the select |
| req_match | input | 2 | Request-side match strobe per counter |
| rsp_match | input | 2 | Response-side match strobe per counter |
| txn_addr | input | 39 | Transaction address, bits 38:7 are compared |
| ext_evt | input | 4 | External reset event pins |
| sample_end | input | 1 | One-cycle end-of-sample strobe |
| cmp_status | output | 2 | Compare status per counter |
| ovf_status | output | 2 | Overflow status per counter |
| range_hit | output | 1 | Registered address window hit |

## Verification
Every result of this block is due exactly one clock edge after the inputs that cause it. This holds for counts, status bits, compare updates, range_hit and rd_data. A reset that follows from the partner's status or qualified event arrives one edge later again, because it uses the partner's registered value. The bench drives inputs at the falling edge and advances a reference model by one cycle on the same inputs. At the next falling edge it compares every output and the addressed register against that model, so each check lands on the cycle in which the result is due.

// File: rtl/evpair_pkg.sv
package evpair_pkg;

  typedef enum logic [1:0] {
    CMP_OFF   = 2'b00,
    CMP_MAX   = 2'b01,
    CMP_HWM   = 2'b10,
    CMP_RANGE = 2'b11
  } cmp_mode_e;

  typedef struct packed {
    logic [2:0] rst_sel;
    cmp_mode_e  mode;
    logic       bus_sel;
  } chan_ctrl_t;

  localparam int CTRL_W = $bits(chan_ctrl_t);
  localparam int N_EXT  = 4;

  localparam logic [2:0] RSEL_PARTNER_STS = 3'b001;
  localparam logic [2:0] RSEL_PARTNER_HIT = 3'b010;

endpackage

// File: rtl/evpair_window.sv
module evpair_window #(
  parameter int FLD_W = 32
) (
  input  logic [FLD_W-1:0] addr_fld,
  input  logic [FLD_W-1:0] lo_bound,
  input  logic [FLD_W-1:0] hi_bound,
  output logic             in_window
);

  logic above_lo;
  logic within_hi;

  always_comb begin
    above_lo  = addr_fld > lo_bound;
    within_hi = addr_fld <= hi_bound;
    in_window = above_lo & within_hi;
  end

endmodule

// File: rtl/evpair_channel.sv
module evpair_channel
  import evpair_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_we,
  input  logic             cmp_we,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] wdata,
  input  logic             req_match,
  input  logic             rsp_match,
  input  logic             range_hit,
  input  logic [N_EXT-1:0] ext_evt,
  input  logic             partner_pulse,
  input  logic             partner_hit,
  input  logic             sample_end,
  output chan_ctrl_t       ctrl_q,
  output logic [CNT_W-1:0] cmp_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             cmp_sts,
  output logic             ovf_sts,
  output logic             sts_pulse,
  output logic             hit_q,
  output logic             clr_evt
);

  localparam int MSB = CNT_W - 1;

  logic             ev_raw;
  logic             qual;
  logic [CNT_W-1:0] cnt_inc;
  logic             bump;
  logic             ovf_hit;
  logic             above;
  logic             cmp_hit;
  logic             sts_clear;
  logic             cmp_sts_d;
  logic             ovf_sts_d;
  logic             pulse_d;

  always_comb begin
    ev_raw = ctrl_q.bus_sel ? rsp_match : req_match;
    qual   = (ctrl_q.mode == CMP_RANGE) ? (ev_raw & range_hit) : ev_raw;

    if (ctrl_q.rst_sel[2])
      clr_evt = ext_evt[ctrl_q.rst_sel[1:0]];
    else if (ctrl_q.rst_sel == RSEL_PARTNER_STS)
      clr_evt = partner_pulse;
    else if (ctrl_q.rst_sel == RSEL_PARTNER_HIT)
      clr_evt = partner_hit;
    else
      clr_evt = 1'b0;

    cnt_inc   = cnt_q + 1'b1;
    bump      = qual & ~cnt_we & ~clr_evt;
    ovf_hit   = bump & cnt_inc[MSB] & ~cnt_q[MSB];
    above     = cnt_q > cmp_q;
    cmp_hit   = (ctrl_q.mode == CMP_MAX) & above;
    sts_clear = clr_evt | ctrl_we;
    cmp_sts_d = sts_clear ? 1'b0 : (cmp_sts | cmp_hit);
    ovf_sts_d = sts_clear ? 1'b0 : (ovf_sts | ovf_hit);
    pulse_d   = (cmp_sts_d | ovf_sts_d) & ~(cmp_sts | ovf_sts);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      cmp_q     <= '0;
      cnt_q     <= '0;
      cmp_sts   <= 1'b0;
      ovf_sts   <= 1'b0;
      sts_pulse <= 1'b0;
      hit_q     <= 1'b0;
    end else begin
      if (ctrl_we)
        ctrl_q <= chan_ctrl_t'(wdata[CTRL_W-1:0]);

      if (cmp_we)
        cmp_q <= wdata;
      else if ((ctrl_q.mode == CMP_HWM) && sample_end && above)
        cmp_q <= cnt_q;

      if (cnt_we)
        cnt_q <= wdata;
      else if (clr_evt)
        cnt_q <= '0;
      else if (qual)
        cnt_q <= cnt_inc;

      cmp_sts   <= cmp_sts_d;
      ovf_sts   <= ovf_sts_d;
      sts_pulse <= pulse_d;
      hit_q     <= qual;
    end
  end

endmodule

// File: rtl/evpair_monitor.sv
module evpair_monitor
  import evpair_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 39,
  parameter int ADDR_LO = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_idx,
  input  logic [1:0]        wr_reg,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              rd_idx,
  input  logic [1:0]        rd_reg,
  output logic [CNT_W-1:0]  rd_data,
  input  logic [1:0]        req_match,
  input  logic [1:0]        rsp_match,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic [N_EXT-1:0]  ext_evt,
  input  logic              sample_end,
  output logic [1:0]        cmp_status,
  output logic [1:0]        ovf_status,
  output logic              range_hit
);

  localparam int FLD_W  = ADDR_W - ADDR_LO;
  localparam int NCH    = 2;
  localparam int STS_LO = 8;

  chan_ctrl_t       ctrl_q [NCH];
  logic [CNT_W-1:0] cmp_q  [NCH];
  logic [CNT_W-1:0] cnt_q  [NCH];
  logic [NCH-1:0]   sts_pulse;
  logic [NCH-1:0]   hit_q;
  logic [NCH-1:0]   clr_evt;
  logic             win_hit;
  logic [CNT_W-1:0] rd_mux;

  logic [2*CNT_W-1:0] cnt_all;
  logic [2*CNT_W-1:0] cmp_all;
  logic [3:0]         mode_all;

  evpair_window #(.FLD_W(FLD_W)) u_win (
    .addr_fld (txn_addr[ADDR_W-1:ADDR_LO]),
    .lo_bound (cmp_q[0][FLD_W-1:0]),
    .hi_bound (cmp_q[1][FLD_W-1:0]),
    .in_window(win_hit)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sel;
    assign sel = wr_en & (wr_idx == 1'(g));

    evpair_channel #(.CNT_W(CNT_W)) u_ch (
      .clk          (clk),
      .rst          (rst),
      .ctrl_we      (sel & (wr_reg == 2'd0)),
      .cmp_we       (sel & (wr_reg == 2'd1)),
      .cnt_we       (sel & (wr_reg == 2'd2)),
      .wdata        (wr_data),
      .req_match    (req_match[g]),
      .rsp_match    (rsp_match[g]),
      .range_hit    (win_hit),
      .ext_evt      (ext_evt),
      .partner_pulse(sts_pulse[NCH-1-g]),
      .partner_hit  (hit_q[NCH-1-g]),
      .sample_end   (sample_end),
      .ctrl_q       (ctrl_q[g]),
      .cmp_q        (cmp_q[g]),
      .cnt_q        (cnt_q[g]),
      .cmp_sts      (cmp_status[g]),
      .ovf_sts      (ovf_status[g]),
      .sts_pulse    (sts_pulse[g]),
      .hit_q        (hit_q[g]),
      .clr_evt      (clr_evt[g])
    );

    assign cnt_all[g*CNT_W +: CNT_W] = cnt_q[g];
    assign cmp_all[g*CNT_W +: CNT_W] = cmp_q[g];
    assign mode_all[g*2 +: 2]        = ctrl_q[g].mode;
  end

  always_comb begin
    rd_mux = '0;
    case (rd_reg)
      2'd0: begin
        rd_mux[CTRL_W-1:0] = ctrl_q[rd_idx];
        rd_mux[STS_LO]     = ovf_status[rd_idx];
        rd_mux[STS_LO+1]   = cmp_status[rd_idx];
      end
      2'd1:    rd_mux = cmp_q[rd_idx];
      2'd2:    rd_mux = cnt_q[rd_idx];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      range_hit <= 1'b0;
    end else begin
      rd_data   <= rd_mux;
      range_hit <= win_hit;
    end
  end

endmodule

// File: rtl/evpair_monitor_chk.sv
module evpair_monitor_chk #(
  parameter int CNT_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic               wr_idx,
  input logic [1:0]         wr_reg,
  input logic [2*CNT_W-1:0] cnt_all,
  input logic [2*CNT_W-1:0] cmp_all,
  input logic [3:0]         mode_all,
  input logic [1:0]         clr_evt,
  input logic [1:0]         cmp_status,
  input logic [1:0]         ovf_status,
  input logic               sample_end
);

  logic wr_ctrl0, wr_cmp0, wr_cnt0;
  assign wr_ctrl0 = wr_en && !wr_idx && wr_reg == 2'd0;
  assign wr_cmp0  = wr_en && !wr_idx && wr_reg == 2'd1;
  assign wr_cnt0  = wr_en && !wr_idx && wr_reg == 2'd2;

  // R1
  status_after_reset_chk: assert property (@(posedge clk)
    rst |=> (cmp_status == 2'b00 && ovf_status == 2'b00));

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_status[0] && !clr_evt[0] && !wr_ctrl0) |=> ovf_status[0]);

  // R4
  max_cmp_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_all[1:0] == 2'b01 && cnt_all[CNT_W-1:0] > cmp_all[CNT_W-1:0]
     && !clr_evt[0] && !wr_ctrl0) |=> cmp_status[0]);

  // R11
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_evt[0] && !wr_cnt0) |=> (cnt_all[CNT_W-1:0] == '0 && !cmp_status[0] && !ovf_status[0]));

  // R6
  cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_cmp0 && !(mode_all[1:0] == 2'b10 && sample_end)) |=> $stable(cmp_all[CNT_W-1:0]));

  // R3
  off_mode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_all[1:0] == 2'b00 && !cmp_status[0]) |=> !cmp_status[0]);

endmodule

bind evpair_monitor evpair_monitor_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .wr_reg    (wr_reg),
  .cnt_all   (cnt_all),
  .cmp_all   (cmp_all),
  .mode_all  (mode_all),
  .clr_evt   (clr_evt),
  .cmp_status(cmp_status),
  .ovf_status(ovf_status),
  .sample_end(sample_end)
);

// File: tb/evpair_monitor_bench.sv
module evpair_monitor_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_idx = 1'b0;
  logic [1:0]  wr_reg = 2'd0;
  logic [31:0] wr_data = '0;
  logic        rd_idx = 1'b0;
  logic [1:0]  rd_reg = 2'd0;
  logic [31:0] rd_data;
  logic [1:0]  req_match = 2'b00;
  logic [1:0]  rsp_match = 2'b00;
  logic [38:0] txn_addr = '0;
  logic [3:0]  ext_evt = 4'h0;
  logic        sample_end = 1'b0;
  logic [1:0]  cmp_status;
  logic [1:0]  ovf_status;
  logic        range_hit;

  always #4 clk = ~clk;

  evpair_monitor u_evpair_monitor (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_reg(wr_reg),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_reg(rd_reg), .rd_data(rd_data),
    .req_match(req_match), .rsp_match(rsp_match), .txn_addr(txn_addr),
    .ext_evt(ext_evt), .sample_end(sample_end), .cmp_status(cmp_status),
    .ovf_status(ovf_status), .range_hit(range_hit)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  string tag = "R1";

  // reference state
  logic [5:0]  m_ctrl [2];
  logic [31:0] m_cmp  [2];
  logic [31:0] m_cnt  [2];
  logic        m_cs   [2];
  logic        m_os   [2];
  logic        m_pul  [2];
  logic        m_hit  [2];
  logic        m_rh;
  logic [31:0] m_rd;

  function automatic logic win_fn(logic [38:0] a, logic [31:0] lo, logic [31:0] hi);
    return (a[38:7] > lo) && (a[38:7] <= hi);
  endfunction

  function automatic logic [31:0] rd_fn(logic i, logic [1:0] r);
    logic [31:0] v = '0;
    if (r == 2'd0) begin
      v[5:0] = m_ctrl[i]; v[8] = m_os[i]; v[9] = m_cs[i];
    end else if (r == 2'd1) v = m_cmp[i];
    else if (r == 2'd2) v = m_cnt[i];
    return v;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_ctrl[i] = '0; m_cmp[i] = '0; m_cnt[i] = '0;
      m_cs[i] = 0; m_os[i] = 0; m_pul[i] = 0; m_hit[i] = 0;
    end
    m_rh = 0; m_rd = '0;
  endtask

  task automatic model_step();
    logic [5:0]  c_ctrl [2];
    logic [31:0] c_cmp [2], c_cnt [2];
    logic        c_cs [2], c_os [2], c_pul [2], c_hit [2];
    logic        rh;
    rh = win_fn(txn_addr, m_cmp[0], m_cmp[1]);
    m_rd = rd_fn(rd_idx, rd_reg);
    for (int i = 0; i < 2; i++) begin
      c_ctrl[i] = m_ctrl[i]; c_cmp[i] = m_cmp[i]; c_cnt[i] = m_cnt[i];
      c_cs[i] = m_cs[i]; c_os[i] = m_os[i]; c_pul[i] = m_pul[i]; c_hit[i] = m_hit[i];
    end
    for (int i = 0; i < 2; i++) begin
      logic [1:0] md = c_ctrl[i][2:1];
      logic [2:0] rs = c_ctrl[i][5:3];
      logic we_ctl = wr_en && wr_idx == 1'(i) && wr_reg == 2'd0;
      logic we_cmp = wr_en && wr_idx == 1'(i) && wr_reg == 2'd1;
      logic we_cnt = wr_en && wr_idx == 1'(i) && wr_reg == 2'd2;
      logic ev = c_ctrl[i][0] ? rsp_match[i] : req_match[i];
      logic q = (md == 2'b11) ? (ev && rh) : ev;
      logic clr = 0;
      logic inc, ovs, cms, any_old;
      if (rs == 3'b001) clr = c_pul[1-i];
      else if (rs == 3'b010) clr = c_hit[1-i];
      else if (rs[2]) clr = ext_evt[rs[1:0]];
      inc = q && !we_cnt && !clr;
      ovs = inc && (c_cnt[i] == 32'h7FFF_FFFF);
      cms = (md == 2'b01) && (c_cnt[i] > c_cmp[i]);
      any_old = c_cs[i] || c_os[i];
      if (clr || we_ctl) begin m_cs[i] = 0; m_os[i] = 0; end
      else begin m_cs[i] = c_cs[i] || cms; m_os[i] = c_os[i] || ovs; end
      m_pul[i] = (m_cs[i] || m_os[i]) && !any_old;
      m_hit[i] = q;
      if (we_cnt) m_cnt[i] = wr_data;
      else if (clr) m_cnt[i] = '0;
      else if (q) m_cnt[i] = c_cnt[i] + 1;
      if (we_cmp) m_cmp[i] = wr_data;
      else if (md == 2'b10 && sample_end && c_cnt[i] > c_cmp[i]) m_cmp[i] = c_cnt[i];
      if (we_ctl) m_ctrl[i] = wr_data[5:0];
    end
    m_rh = rh;
  endtask

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s (%s) got %h exp %h at %0t", req, tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R4 cmp_status", {30'd0, cmp_status}, {30'd0, m_cs[1], m_cs[0]});
    check("R5 ovf_status", {30'd0, ovf_status}, {30'd0, m_os[1], m_os[0]});
    check("R7 range_hit", {31'd0, range_hit}, {31'd0, m_rh});
    check("R12 rd_data", rd_data, m_rd);
  endtask

  // one clock: inputs already driven at the falling edge
  task automatic step();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    wr_en = 1'b0;
    sample_end = 1'b0;
  endtask

  task automatic wr(logic i, logic [1:0] r, logic [31:0] d);
    wr_en = 1'b1; wr_idx = i; wr_reg = r; wr_data = d;
    step();
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      rd_idx = 1'(k); rd_reg = 2'(k);
      step();
    end
  endtask

  task automatic quiet();
    req_match = 0; rsp_match = 0; ext_evt = 0; sample_end = 0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired (all requirements)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7351));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tag = "R1 reset state";
    compare_all();
    for (int i = 0; i < 2; i++)
      for (int r = 0; r < 3; r++) begin
        rd_idx = 1'(i); rd_reg = 2'(r);
        step();
      end

    // R2: bus select per counter
    tag = "R2 bus select";
    wr(1'b1, 2'd0, 32'h01);
    req_match = 2'b11; idle(3);
    quiet(); rsp_match = 2'b11; idle(2);
    quiet(); rd_reg = 2'd2; rd_idx = 0; step();

    // R3: compare off with low threshold
    tag = "R3 compare off";
    wr(1'b0, 2'd1, 32'd1);
    req_match = 2'b01; idle(4); quiet();

    // R4 and R8: max compare on counter 0, counter 1 resets on partner status
    tag = "R4 R8 max compare and partner status reset";
    wr(1'b1, 2'd0, {26'd0, 3'b001, 2'b00, 1'b0});
    wr(1'b0, 2'd2, 32'd0);
    wr(1'b0, 2'd0, {26'd0, 3'b000, 2'b01, 1'b0});
    req_match = 2'b11; idle(6); quiet(); idle(2);

    // R5: overflow into bit 31
    tag = "R5 overflow";
    wr(1'b0, 2'd0, 32'h0);
    wr(1'b0, 2'd2, 32'h7FFF_FFFE);
    req_match = 2'b01; idle(3); quiet(); idle(2);
    wr(1'b0, 2'd0, 32'h0); idle(1);

    // R10 and R11: external pin reset wins over increment
    tag = "R10 R11 pin reset";
    wr(1'b1, 2'd0, {26'd0, 3'b101, 2'b00, 1'b0});
    req_match = 2'b10; idle(3);
    ext_evt = 4'b0010; idle(1); ext_evt = 4'b0001; idle(1);
    quiet(); wr(1'b1, 2'd0, {26'd0, 3'b011, 2'b00, 1'b0});
    ext_evt = 4'hF; req_match = 2'b10; idle(2); quiet();

    // R6: high-water mark
    tag = "R6 high water mark";
    wr(1'b0, 2'd0, {26'd0, 3'b000, 2'b10, 1'b0});
    wr(1'b0, 2'd1, 32'd3);
    wr(1'b0, 2'd2, 32'd9);
    sample_end = 1'b1; step();
    wr(1'b0, 2'd2, 32'd2);
    sample_end = 1'b1; step();
    rd_idx = 0; rd_reg = 2'd1; step();

    // R7 and R9: address window, counter 1 resets on partner hit
    tag = "R7 R9 address window";
    wr(1'b0, 2'd1, 32'd10);
    wr(1'b1, 2'd1, 32'd20);
    wr(1'b0, 2'd0, {26'd0, 3'b000, 2'b11, 1'b0});
    wr(1'b1, 2'd0, {26'd0, 3'b010, 2'b00, 1'b0});
    req_match = 2'b11;
    foreach (txn_addr[k]) if (k < 6) begin
      logic [31:0] f;
      f = (k == 0) ? 32'd10 : (k == 1) ? 32'd11 : (k == 2) ? 32'd20 :
          (k == 3) ? 32'd21 : (k == 4) ? 32'd15 : 32'd0;
      txn_addr = {f, 7'h55};
      step();
    end
    quiet(); idle(2);

    // randomized mix covering all requirements
    tag = "R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 random";
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(7) == 0) begin
        wr_en = 1'b1;
        wr_idx = 1'($urandom_range(1));
        wr_reg = 2'($urandom_range(2));
        case (wr_reg)
          2'd0: wr_data = 32'($urandom_range(63));
          2'd1: wr_data = 32'($urandom_range(40));
          default: wr_data = ($urandom_range(3) == 0) ?
                     32'h7FFF_FFF8 + 32'($urandom_range(15)) : 32'($urandom_range(30));
        endcase
      end
      req_match  = 2'($urandom);
      rsp_match  = 2'($urandom);
      ext_evt    = ($urandom_range(15) == 0) ? 4'($urandom) : 4'h0;
      sample_end = ($urandom_range(7) == 0);
      txn_addr   = {32'($urandom_range(45)), 7'($urandom)};
      rd_idx     = 1'($urandom_range(1));
      rd_reg     = 2'($urandom_range(3));
      step();
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule